// File: doc/BRIEF.md
# Sleep Mode and Clock Gating Controller

This block takes a small processor system into a low-power state when the CPU asks for one, and brings it back out. Software first programs a three-bit sleep mode, a sleep-enable bit and a stabilisation count through a configuration write. A later sleep request then gates the CPU clock and switches off other clock domains and oscillators according to the chosen mode. The mode is captured when sleep begins, so a configuration write made during sleep has no effect on that sleep.

Each mode has its own set of qualifying wake events. When one arrives, the block turns on any oscillator that the mode had stopped and keeps the CPU clock gated until the programmed count has run out. It then returns to active operation. A separate stop mask turns off individual peripheral clocks. The mask applies both while running and while in the shallowest sleep mode.

The outputs are clock-enable and oscillator-enable levels meant for clock gates and oscillator control. The CPU core appears only as the sleep-request input.

Top module: `pwr_sleep_ctrl`

## Requirements
- R1: After reset the controller is running. The CPU clock, the system domain clock, every peripheral clock, the system oscillator and the RTC oscillator are all enabled. The stop mask is cleared, the mode field is 0, sleep-enable is 0 and the stabilisation count is 16.
- R2: A sleep request made while sleep-enable is 0 is ignored. The CPU clock stays enabled.
- R3: Idle is mode 0. In idle only the CPU clock stops. The system domain clock, both oscillators and the unmasked peripheral clocks keep running.
- R4: Power-down is mode 2. It disables both oscillators, the system domain clock and every peripheral clock. Only the two-wire or pin-change wake inputs end it, and the RTC and general interrupt inputs are ignored.
- R5: Power-save is mode 3. It behaves like power-down, except that the RTC oscillator stays on and the RTC wake input also ends it.
- R6: Standby is mode 6. It behaves like power-down, except that the system oscillator stays on. A two-wire or pin-change wake restores the CPU clock one cycle later, with no stabilisation wait.
- R7: Extended standby is mode 7. It keeps both oscillators on and also accepts the RTC wake. A wake restores the CPU clock one cycle later.
- R8: A wake from power-down or power-save turns both oscillators on in the next cycle. The CPU clock then stays gated for the programmed count plus one cycle.
- R9: Stop mask bit i, when set, gates peripheral clock i while running and while in idle.
- R10: Mode encodings 1, 4 and 5 behave exactly as idle.
- R11: Idle ends on any of the four wake inputs, including the general interrupt input. The CPU clock returns one cycle later.
- R12: The mode is captured when sleep starts. A configuration write during sleep does not change the oscillator profile or the wake sources of that sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Loads cfg_mode, cfg_sleep_en and cfg_stab |
| cfg_mode | input | 3 | Sleep mode field |
| cfg_sleep_en | input | 1 | Sleep-enable bit |
| cfg_stab | input | STAB_W | Oscillator stabilisation count |
| stop_wr | input | 1 | Loads the peripheral stop mask |
| stop_data | input | NUM_PERIPH | New stop mask, 1 = clock stopped |
| sleep_req | input | 1 | Sleep request from the CPU |
| wake_irq | input | 1 | Any enabled interrupt (wakes idle only) |
| wake_twi | input | 1 | Two-wire interface interrupt |
| wake_pin | input | 1 | Pin-change interrupt |
| wake_rtc | input | 1 | Real-time counter interrupt |
| cpu_clk_en | output | 1 | CPU clock enable |
| sys_clk_en | output | 1 | Memory, DMA, event and interrupt domain clock enable |
| periph_clk_en | output | NUM_PERIPH | Per-peripheral clock enables |
| sys_osc_en | output | 1 | System oscillator enable |
| rtc_osc_en | output | 1 | RTC oscillator enable |

## Verification
The bench targets wake inputs that must be ignored. If power-down accepted the RTC or general interrupt input, or standby accepted the RTC input, the CPU clock would return too early. It also measures the settle window exactly. An off-by-one counter, or a settle wait left out of power-save, would ungate the CPU clock a cycle early, while a standby that waited anyway would show a late return. Other tests exercise unused mode encodings, stop masks during idle, a configuration write during power-down, and a reset during sleep that must clear the stop mask.

// File: rtl/pwr_sleep_pkg.sv
package pwr_sleep_pkg;

   localparam logic [2:0] MODE_IDLE  = 3'd0;
   localparam logic [2:0] MODE_PDOWN = 3'd2;
   localparam logic [2:0] MODE_PSAVE = 3'd3;
   localparam logic [2:0] MODE_STBY  = 3'd6;
   localparam logic [2:0] MODE_XSTBY = 3'd7;

   typedef enum logic [1:0] {
      PS_RUN    = 2'd0,
      PS_SLEEP  = 2'd1,
      PS_SETTLE = 2'd2
   } pwr_state_e;

   // what stays alive while asleep, and what may end the sleep
   typedef struct packed {
      logic keep_sys_clk;
      logic keep_sys_osc;
      logic keep_rtc_osc;
      logic wake_on_irq;
      logic wake_on_rtc;
   } pwr_profile_t;

endpackage

// File: rtl/pwr_profile_lookup.sv
module pwr_profile_lookup
   import pwr_sleep_pkg::*;
(
   input  logic [2:0]   mode,
   output pwr_profile_t prof
);

   always_comb begin
      unique case (mode)
         MODE_PDOWN: prof = '{keep_sys_clk: 1'b0, keep_sys_osc: 1'b0, keep_rtc_osc: 1'b0,
                              wake_on_irq: 1'b0, wake_on_rtc: 1'b0};
         MODE_PSAVE: prof = '{keep_sys_clk: 1'b0, keep_sys_osc: 1'b0, keep_rtc_osc: 1'b1,
                              wake_on_irq: 1'b0, wake_on_rtc: 1'b1};
         MODE_STBY:  prof = '{keep_sys_clk: 1'b0, keep_sys_osc: 1'b1, keep_rtc_osc: 1'b0,
                              wake_on_irq: 1'b0, wake_on_rtc: 1'b0};
         MODE_XSTBY: prof = '{keep_sys_clk: 1'b0, keep_sys_osc: 1'b1, keep_rtc_osc: 1'b1,
                              wake_on_irq: 1'b0, wake_on_rtc: 1'b1};
         default:    prof = '{keep_sys_clk: 1'b1, keep_sys_osc: 1'b1, keep_rtc_osc: 1'b1,
                              wake_on_irq: 1'b1, wake_on_rtc: 1'b1};
      endcase
   end

endmodule

// File: rtl/pwr_cfg_regs.sv
module pwr_cfg_regs #(
   parameter int NUM_PERIPH = 8,
   parameter int STAB_W     = 8,
   parameter int STAB_RESET = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_wr,
   input  logic [2:0]            cfg_mode,
   input  logic                  cfg_sleep_en,
   input  logic [STAB_W-1:0]     cfg_stab,
   input  logic                  stop_wr,
   input  logic [NUM_PERIPH-1:0] stop_data,
   output logic [2:0]            mode_q,
   output logic                  sleep_en_q,
   output logic [STAB_W-1:0]     stab_q,
   output logic [NUM_PERIPH-1:0] stop_q
);

   localparam logic [STAB_W-1:0] STAB_INIT = STAB_W'(STAB_RESET);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q     <= 3'd0;
         sleep_en_q <= 1'b0;
         stab_q     <= STAB_INIT;
      end else if (cfg_wr) begin
         mode_q     <= cfg_mode;
         sleep_en_q <= cfg_sleep_en;
         stab_q     <= cfg_stab;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       stop_q <= '0;
      else if (stop_wr) stop_q <= stop_data;
   end

endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
   import pwr_sleep_pkg::*;
#(
   parameter int STAB_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sleep_req,
   input  logic              sleep_en,
   input  logic [2:0]        mode_cfg,
   input  logic [STAB_W-1:0] stab_cfg,
   input  pwr_profile_t      prof,
   input  logic              wake_irq,
   input  logic              wake_twi,
   input  logic              wake_pin,
   input  logic              wake_rtc,
   output pwr_state_e        state,
   output logic [2:0]        mode_lat
);

   logic [STAB_W-1:0] cnt_q;
   logic              wake_ok;
   logic              cnt_done;

   assign wake_ok  = wake_twi | wake_pin
                   | (prof.wake_on_rtc & wake_rtc)
                   | (prof.wake_on_irq & wake_irq);
   assign cnt_done = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= PS_RUN;
         mode_lat <= MODE_IDLE;
         cnt_q    <= '0;
      end else begin
         unique case (state)
            PS_RUN: begin
               if (sleep_req && sleep_en) begin
                  state    <= PS_SLEEP;
                  mode_lat <= mode_cfg;
               end
            end
            PS_SLEEP: begin
               if (wake_ok) begin
                  if (prof.keep_sys_osc) begin
                     state <= PS_RUN;
                  end else begin
                     state <= PS_SETTLE;
                     cnt_q <= stab_cfg;
                  end
               end
            end
            PS_SETTLE: begin
               if (cnt_done) state <= PS_RUN;
               else          cnt_q <= cnt_q - 1'b1;
            end
            default: state <= PS_RUN;
         endcase
      end
   end

endmodule

// File: rtl/pwr_clk_gate.sv
module pwr_clk_gate
   import pwr_sleep_pkg::*;
#(
   parameter int NUM_PERIPH     = 8,
   parameter bit PERIPH_STOP_EN = 1'b1
) (
   input  pwr_state_e            state,
   input  pwr_profile_t          prof,
   input  logic [NUM_PERIPH-1:0] stop_q,
   output logic                  cpu_clk_en,
   output logic                  sys_clk_en,
   output logic                  sys_osc_en,
   output logic                  rtc_osc_en,
   output logic [NUM_PERIPH-1:0] periph_clk_en
);

   logic run;
   logic asleep;

   assign run    = (state == PS_RUN);
   assign asleep = (state == PS_SLEEP);

   assign cpu_clk_en = run;
   assign sys_clk_en = run | (asleep & prof.keep_sys_clk);
   assign sys_osc_en = ~asleep | prof.keep_sys_osc;
   assign rtc_osc_en = ~asleep | prof.keep_rtc_osc;

   for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_periph
      if (PERIPH_STOP_EN) begin : g_stoppable
         assign periph_clk_en[i] = sys_clk_en & ~stop_q[i];
      end else begin : g_fixed
         assign periph_clk_en[i] = sys_clk_en;
      end
   end

endmodule

// File: rtl/pwr_sleep_ctrl.sv
module pwr_sleep_ctrl
   import pwr_sleep_pkg::*;
#(
   parameter int NUM_PERIPH     = 8,
   parameter int STAB_W         = 8,
   parameter int STAB_RESET     = 16,
   parameter bit PERIPH_STOP_EN = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_wr,
   input  logic [2:0]            cfg_mode,
   input  logic                  cfg_sleep_en,
   input  logic [STAB_W-1:0]     cfg_stab,
   input  logic                  stop_wr,
   input  logic [NUM_PERIPH-1:0] stop_data,
   input  logic                  sleep_req,
   input  logic                  wake_irq,
   input  logic                  wake_twi,
   input  logic                  wake_pin,
   input  logic                  wake_rtc,
   output logic                  cpu_clk_en,
   output logic                  sys_clk_en,
   output logic [NUM_PERIPH-1:0] periph_clk_en,
   output logic                  sys_osc_en,
   output logic                  rtc_osc_en
);

   if (NUM_PERIPH < 1 || NUM_PERIPH > 64) begin : g_bad_periph
      $error("pwr_sleep_ctrl: NUM_PERIPH must lie in 1..64");
   end
   if (STAB_W < 1 || STAB_W > 24) begin : g_bad_stab_w
      $error("pwr_sleep_ctrl: STAB_W must lie in 1..24");
   end
   if (STAB_RESET < 0 || STAB_RESET >= (1 << STAB_W)) begin : g_bad_stab_rst
      $error("pwr_sleep_ctrl: STAB_RESET does not fit in STAB_W bits");
   end

   logic [2:0]            mode_q;
   logic                  sleep_en_q;
   logic [STAB_W-1:0]     stab_q;
   logic [NUM_PERIPH-1:0] stop_q;
   pwr_state_e            st;
   logic [2:0]            mode_lat;
   pwr_profile_t          prof;

   pwr_cfg_regs #(
      .NUM_PERIPH (NUM_PERIPH),
      .STAB_W     (STAB_W),
      .STAB_RESET (STAB_RESET)
   ) i_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_wr       (cfg_wr),
      .cfg_mode     (cfg_mode),
      .cfg_sleep_en (cfg_sleep_en),
      .cfg_stab     (cfg_stab),
      .stop_wr      (stop_wr),
      .stop_data    (stop_data),
      .mode_q       (mode_q),
      .sleep_en_q   (sleep_en_q),
      .stab_q       (stab_q),
      .stop_q       (stop_q)
   );

   pwr_profile_lookup i_lookup (
      .mode (mode_lat),
      .prof (prof)
   );

   pwr_seq_fsm #(
      .STAB_W (STAB_W)
   ) i_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .sleep_req (sleep_req),
      .sleep_en  (sleep_en_q),
      .mode_cfg  (mode_q),
      .stab_cfg  (stab_q),
      .prof      (prof),
      .wake_irq  (wake_irq),
      .wake_twi  (wake_twi),
      .wake_pin  (wake_pin),
      .wake_rtc  (wake_rtc),
      .state     (st),
      .mode_lat  (mode_lat)
   );

   pwr_clk_gate #(
      .NUM_PERIPH     (NUM_PERIPH),
      .PERIPH_STOP_EN (PERIPH_STOP_EN)
   ) i_gate (
      .state         (st),
      .prof          (prof),
      .stop_q        (stop_q),
      .cpu_clk_en    (cpu_clk_en),
      .sys_clk_en    (sys_clk_en),
      .sys_osc_en    (sys_osc_en),
      .rtc_osc_en    (rtc_osc_en),
      .periph_clk_en (periph_clk_en)
   );

endmodule

// File: rtl/pwr_sleep_ctrl_chk.sv
module pwr_sleep_ctrl_chk #(
   parameter int NUM_PERIPH     = 8,
   parameter bit PERIPH_STOP_EN = 1'b1
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [1:0]            st,
   input logic [2:0]            mode_lat,
   input logic                  sleep_en_q,
   input logic [NUM_PERIPH-1:0] stop_q,
   input logic                  sleep_req,
   input logic                  wake_twi,
   input logic                  wake_pin,
   input logic                  cpu_clk_en,
   input logic                  sys_clk_en,
   input logic [NUM_PERIPH-1:0] periph_clk_en,
   input logic                  sys_osc_en,
   input logic                  rtc_osc_en
);

   logic in_sleep;
   logic idle_like;
   assign in_sleep  = (st == 2'd1);
   assign idle_like = !(mode_lat == 3'd2 || mode_lat == 3'd3 ||
                        mode_lat == 3'd6 || mode_lat == 3'd7);

   assert_osc_before_cpu_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !sys_osc_en |-> !cpu_clk_en);

   assert_req_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_clk_en && sleep_req && !sleep_en_q) |=> cpu_clk_en);

   assert_pdown_all_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_sleep && mode_lat == 3'd2) |-> (!sys_osc_en && !rtc_osc_en && !sys_clk_en));

   assert_pdown_wake_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_sleep && mode_lat == 3'd2 && !wake_twi && !wake_pin) |=> !cpu_clk_en);

   assert_psave_rtc_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_sleep && mode_lat == 3'd3) |-> (rtc_osc_en && !sys_osc_en));

   assert_stby_fast_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_sleep && mode_lat == 3'd6 && (wake_twi || wake_pin)) |=> cpu_clk_en);

   assert_idle_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_sleep && idle_like) |-> (sys_clk_en && sys_osc_en && rtc_osc_en && !cpu_clk_en));

   if (PERIPH_STOP_EN) begin : g_stop_chk
      assert_periph_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
         cpu_clk_en |-> (periph_clk_en == ~stop_q));
   end

endmodule

bind pwr_sleep_ctrl pwr_sleep_ctrl_chk #(
   .NUM_PERIPH     (NUM_PERIPH),
   .PERIPH_STOP_EN (PERIPH_STOP_EN)
) i_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .st            (st),
   .mode_lat      (mode_lat),
   .sleep_en_q    (sleep_en_q),
   .stop_q        (stop_q),
   .sleep_req     (sleep_req),
   .wake_twi      (wake_twi),
   .wake_pin      (wake_pin),
   .cpu_clk_en    (cpu_clk_en),
   .sys_clk_en    (sys_clk_en),
   .periph_clk_en (periph_clk_en),
   .sys_osc_en    (sys_osc_en),
   .rtc_osc_en    (rtc_osc_en)
);

// File: tb/test_pwr_sleep_ctrl.sv
`timescale 1ns/1ps
module test_pwr_sleep_ctrl;

   localparam int NP = 8;
   localparam int SW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_wr = 1'b0;
   logic [2:0]    cfg_mode = '0;
   logic          cfg_sleep_en = 1'b0;
   logic [SW-1:0] cfg_stab = '0;
   logic          stop_wr = 1'b0;
   logic [NP-1:0] stop_data = '0;
   logic          sleep_req = 1'b0;
   logic          wake_irq = 1'b0, wake_twi = 1'b0, wake_pin = 1'b0, wake_rtc = 1'b0;
   logic          cpu_clk_en, sys_clk_en, sys_osc_en, rtc_osc_en;
   logic [NP-1:0] periph_clk_en;

   int checks = 0;
   int errors = 0;
   bit started = 1'b0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   pwr_sleep_ctrl i_pwr_sleep_ctrl (
      .clk (clk), .rst_n (rst_n),
      .cfg_wr (cfg_wr), .cfg_mode (cfg_mode), .cfg_sleep_en (cfg_sleep_en), .cfg_stab (cfg_stab),
      .stop_wr (stop_wr), .stop_data (stop_data), .sleep_req (sleep_req),
      .wake_irq (wake_irq), .wake_twi (wake_twi), .wake_pin (wake_pin), .wake_rtc (wake_rtc),
      .cpu_clk_en (cpu_clk_en), .sys_clk_en (sys_clk_en), .periph_clk_en (periph_clk_en),
      .sys_osc_en (sys_osc_en), .rtc_osc_en (rtc_osc_en)
   );

   // ---------------- behavioural reference ----------------
   int m_st = 0;          // 0 running, 1 asleep, 2 settling
   int m_mode = 0;        // mode captured at sleep entry
   int m_cnt = 0;
   int m_cfg_mode = 0;
   int m_en = 0;
   int m_stab = 16;
   logic [NP-1:0] m_stop = '0;

   function automatic int eff_mode(int md);
      return (md == 2 || md == 3 || md == 6 || md == 7) ? md : 0;
   endfunction

   function automatic bit may_wake(int md);
      bit common = wake_twi | wake_pin;
      case (md)
         0:       return common | wake_irq | wake_rtc;
         3, 7:    return common | wake_rtc;
         default: return common;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st = 0; m_mode = 0; m_cnt = 0; m_cfg_mode = 0; m_en = 0; m_stab = 16; m_stop = '0;
      end else begin
         if (m_st == 0) begin
            if (sleep_req && m_en != 0) begin m_st = 1; m_mode = eff_mode(m_cfg_mode); end
         end else if (m_st == 1) begin
            if (may_wake(m_mode)) begin
               if (m_mode == 2 || m_mode == 3) begin m_st = 2; m_cnt = m_stab; end
               else m_st = 0;
            end
         end else begin
            if (m_cnt == 0) m_st = 0;
            else m_cnt = m_cnt - 1;
         end
         if (cfg_wr) begin m_cfg_mode = int'(cfg_mode); m_en = int'(cfg_sleep_en); m_stab = int'(cfg_stab); end
         if (stop_wr) m_stop = stop_data;
      end
   end

   function automatic logic [NP+3:0] exp_vec();
      // {cpu, sys, sys_osc, rtc_osc, periph}
      if (m_st == 0) return {4'b1111, ~m_stop};
      if (m_st == 2) return {4'b0011, {NP{1'b0}}};
      case (m_mode)
         2:       return {4'b0000, {NP{1'b0}}};
         3:       return {4'b0001, {NP{1'b0}}};
         6:       return {4'b0010, {NP{1'b0}}};
         7:       return {4'b0011, {NP{1'b0}}};
         default: return {4'b0111, ~m_stop};
      endcase
   endfunction

   function automatic string cur_tag();
      if (m_st == 2) return "R8";
      if (m_st == 0) return "R9";
      case (m_mode)
         2: return "R4";
         3: return "R5";
         6: return "R6";
         7: return "R7";
         default: return "R3";
      endcase
   endfunction

   always @(negedge clk) begin
      if (started && rst_n && !done) begin
         logic [NP+3:0] act;
         logic [NP+3:0] ex;
         act = {cpu_clk_en, sys_clk_en, sys_osc_en, rtc_osc_en, periph_clk_en};
         ex  = exp_vec();
         checks++;
         if (act !== ex) begin
            errors++;
            $display("FAIL %s model compare: actual %b expected %b at %0t", cur_tag(), act, ex, $time);
         end
      end
   end

   // ---------------- directed checks ----------------
   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] ex);
      checks++;
      if (act !== ex) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, ex, $time);
      end
   endtask

   task automatic step(input int n = 1);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic wr_cfg(input logic [2:0] md, input logic en, input logic [SW-1:0] stb);
      cfg_wr = 1'b1; cfg_mode = md; cfg_sleep_en = en; cfg_stab = stb;
      step(); cfg_wr = 1'b0;
   endtask

   task automatic wr_stop(input logic [NP-1:0] m);
      stop_wr = 1'b1; stop_data = m; step(); stop_wr = 1'b0;
   endtask

   task automatic go_sleep();
      sleep_req = 1'b1; step(); sleep_req = 1'b0;
   endtask

   task automatic pulse(input int which);  // 0 irq 1 twi 2 pin 3 rtc
      wake_irq = (which == 0); wake_twi = (which == 1);
      wake_pin = (which == 2); wake_rtc = (which == 3);
      step();
      wake_irq = 1'b0; wake_twi = 1'b0; wake_pin = 1'b0; wake_rtc = 1'b0;
   endtask

   initial begin
      step(2);
      rst_n = 1'b1;
      step();
      started = 1'b1;
      chk("R1 reset enables", {cpu_clk_en, sys_clk_en, sys_osc_en, rtc_osc_en, periph_clk_en},
          {4'b1111, {NP{1'b1}}});

      go_sleep();
      chk("R2 request with enable clear", cpu_clk_en, 1'b1);

      wr_stop(8'hA5);
      chk("R9 stop mask while running", periph_clk_en, 8'h5A);

      wr_cfg(3'd0, 1'b1, 8'd3);
      go_sleep();
      chk("R3 idle cpu gated", cpu_clk_en, 1'b0);
      chk("R3 idle sys and osc kept", {sys_clk_en, sys_osc_en, rtc_osc_en}, 3'b111);
      chk("R9 stop mask in idle", periph_clk_en, 8'h5A);
      pulse(0);
      chk("R11 idle wakes on irq", cpu_clk_en, 1'b1);

      wr_cfg(3'd4, 1'b1, 8'd3);
      go_sleep();
      chk("R10 mode 4 acts as idle", {cpu_clk_en, sys_clk_en, sys_osc_en}, 3'b011);
      pulse(3);
      chk("R10 mode 4 wakes on rtc", cpu_clk_en, 1'b1);

      wr_cfg(3'd2, 1'b1, 8'd3);
      go_sleep();
      chk("R4 power-down all off", {sys_clk_en, sys_osc_en, rtc_osc_en, periph_clk_en}, 11'd0);
      pulse(0);
      pulse(3);
      step();
      chk("R4 irq and rtc ignored", {cpu_clk_en, sys_osc_en}, 2'b00);
      pulse(2);
      chk("R8 oscillators back on", {cpu_clk_en, sys_osc_en, rtc_osc_en}, 3'b011);
      step(3);
      chk("R8 cpu still gated at count end", cpu_clk_en, 1'b0);
      step();
      chk("R8 cpu ungated after count+1", cpu_clk_en, 1'b1);

      wr_cfg(3'd3, 1'b1, 8'd0);
      go_sleep();
      chk("R5 power-save rtc kept", {sys_osc_en, rtc_osc_en}, 2'b01);
      pulse(3);
      chk("R5 rtc wake starts settle", {cpu_clk_en, sys_osc_en}, 2'b01);
      step();
      chk("R5 R8 zero count one settle cycle", cpu_clk_en, 1'b1);

      wr_cfg(3'd6, 1'b1, 8'd5);
      go_sleep();
      chk("R6 standby osc profile", {sys_osc_en, rtc_osc_en, sys_clk_en}, 3'b100);
      pulse(3);
      chk("R6 rtc ignored", cpu_clk_en, 1'b0);
      pulse(1);
      chk("R6 fast wake on twi", cpu_clk_en, 1'b1);

      wr_cfg(3'd7, 1'b1, 8'd5);
      go_sleep();
      chk("R7 extended standby osc", {sys_osc_en, rtc_osc_en, sys_clk_en}, 3'b110);
      pulse(0);
      chk("R7 irq ignored", cpu_clk_en, 1'b0);
      pulse(3);
      chk("R7 fast wake on rtc", cpu_clk_en, 1'b1);

      wr_cfg(3'd2, 1'b1, 8'd1);
      go_sleep();
      wr_cfg(3'd0, 1'b1, 8'd1);
      chk("R12 profile held after cfg write", {sys_osc_en, sys_clk_en}, 2'b00);
      pulse(0);
      chk("R12 idle wake still ignored", cpu_clk_en, 1'b0);
      pulse(1);
      step(2);
      chk("R12 settle from captured mode", cpu_clk_en, 1'b1);

      wr_cfg(3'd2, 1'b1, 8'd1);
      go_sleep();
      rst_n = 1'b0;
      step();
      rst_n = 1'b1;
      step();
      chk("R1 reset during sleep", {cpu_clk_en, sys_clk_en, sys_osc_en, rtc_osc_en, periph_clk_en},
          {4'b1111, {NP{1'b1}}});
      go_sleep();
      chk("R1 R2 sleep-enable cleared by reset", cpu_clk_en, 1'b1);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule